// File: doc/BRIEF.md
# Counted Loop Branch Unit

This block keeps a private loop counter, held apart from the general register file, and resolves the combined "decrement, test and branch" instruction used to close counted loops. A single request decrements the counter, checks the new value against zero and selects either the branch target or the next sequential address. This replaces a separate subtract instruction followed by a compare-and-branch.

Software loads the counter with a move operation that carries a 32-bit value. The current counter value is always visible on a read port. A branch request carries the program counter of the branch and a signed word offset. One cycle later the unit returns a valid strobe, a taken flag and the resolved next address. The counter change from a request is visible on the read port in that same cycle.

Top module: `lcbr_unit`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, `cnt_o` reads 0 and `res_valid_o` is 0.
- R2: A move request (`mv_en_i`=1) with no branch request writes `mv_val_i` into the counter. The new value appears on `cnt_o` in the next cycle.
- R3: A branch request (`br_en_i`=1) with no move request leaves the old counter value minus one on `cnt_o` in the next cycle.
- R4: When the decremented value is nonzero, the result has `res_taken_o`=1 and `res_addr_o` = PC + (sign-extended word offset × 4).
- R5: When the decremented value is zero, the result has `res_taken_o`=0 and `res_addr_o` = PC + 4.
- R6: A branch on a counter of 0 wraps the counter to 0xFFFFFFFF. It counts as nonzero, so the branch is taken.
- R7: When a move and a branch arrive in the same cycle, the branch works on the moved value. The counter becomes `mv_val_i` − 1, and the taken flag follows from that value.
- R8: `res_valid_o` is 1 exactly in the cycle after a branch request and 0 otherwise. A cycle with no request leaves `cnt_o` unchanged.
- R9: The branch offset is a two's-complement word count of OFF_W bits (default 14). Its top bit is the sign, so a negative offset yields a target below PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mv_en_i | input | 1 | Move-to-counter request |
| mv_val_i | input | 32 | Value to load into the counter |
| br_en_i | input | 1 | Counted branch request |
| br_pc_i | input | 32 | Address of the branch instruction |
| br_off_i | input | 14 | Signed word offset of the target |
| cnt_o | output | 32 | Current counter value |
| res_valid_o | output | 1 | Branch result valid |
| res_taken_o | output | 1 | Branch taken flag |
| res_addr_o | output | 32 | Resolved next address |

## Verification
The bench walks a loop of three iterations down to its exit. A design that tested the counter before the decrement instead of after it would take the last iteration once too often, or leave it one iteration early. A branch on a zero counter checks the wrap case: a design that saturated, or treated the wrap as zero, would fall through instead of branching. Same-cycle move and branch requests, using moved values of 1 and 5, check ordering: a design that gave the branch the stale counter, or let the move overwrite the decrement, would report the wrong flag or the wrong counter. A negative offset catches zero-extension of the offset, which would produce a target far above PC.

// File: rtl/lcbr_pkg.sv
// Package: shared widths and the result record for the counted loop branch unit.
// Assumes a byte-addressed machine with 4-byte instructions.
package lcbr_pkg;
    parameter int DATA_W_DEF = 32;
    parameter int OFF_W_DEF  = 14;
    parameter int INSN_BYTES = 4;

    typedef struct packed {
        logic                  taken;
        logic [DATA_W_DEF-1:0] addr;
    } lcbr_res_t;
endpackage

// File: rtl/lcbr_count_reg.sv
// Module: the private loop counter.
// It picks the operand (a moved value overrides the stored count), forms the
// decremented value for a branch and stores the next count.
// Assumes: the move has priority as a source, and the branch then consumes that value.
module lcbr_count_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mv_en,
    input  logic [DATA_W-1:0] mv_val,
    input  logic              br_en,
    output logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] cnt_dec,
    output logic              dec_nonzero
);
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] cnt_nxt;

    // Select the operand the branch sees: a same-cycle move wins.
    always_comb begin
        operand = mv_en ? mv_val : cnt;
    end

    // Decrement with natural wrap-around and test the result for zero.
    always_comb begin
        cnt_dec     = operand - DATA_W'(1);
        dec_nonzero = |cnt_dec;
    end

    // Choose the next stored count: branch result, moved value, or hold.
    always_comb begin
        if (br_en)
            cnt_nxt = cnt_dec;
        else if (mv_en)
            cnt_nxt = mv_val;
        else
            cnt_nxt = cnt;
    end

    // Counter storage with synchronous active-low reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end
endmodule

// File: rtl/lcbr_target_calc.sv
// Module: computes the resolved next address of a counted branch.
// Taken: PC plus the sign-extended word offset scaled to bytes. Not taken: PC plus one instruction.
// Assumes OFF_W + SHIFT <= DATA_W.
module lcbr_target_calc #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 14,
    parameter int SHIFT  = 2
) (
    input  logic [DATA_W-1:0] pc,
    input  logic [OFF_W-1:0]  off,
    input  logic              taken,
    output logic [DATA_W-1:0] next_addr
);
    localparam int EXT_W = DATA_W - OFF_W - SHIFT;

    logic [DATA_W-1:0] off_bytes;
    logic [DATA_W-1:0] tgt;
    logic [DATA_W-1:0] seq;

    // Sign-extend the word offset and scale it to a byte displacement.
    generate
        if (EXT_W > 0) begin : g_ext
            always_comb off_bytes = {{EXT_W{off[OFF_W-1]}}, off, {SHIFT{1'b0}}};
        end else begin : g_noext
            always_comb off_bytes = {off, {SHIFT{1'b0}}};
        end
    endgenerate

    // Form both candidate addresses and select one by the taken flag.
    always_comb begin
        tgt       = pc + off_bytes;
        seq       = pc + DATA_W'(1 << SHIFT);
        next_addr = taken ? tgt : seq;
    end
endmodule

// File: rtl/lcbr_result_reg.sv
// Module: result stage. It registers the valid strobe and the branch outcome one cycle after the request.
// Assumes the outcome fields matter only while valid is high; they are reset to zero anyway.
module lcbr_result_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              taken_in,
    input  logic [DATA_W-1:0] addr_in,
    output logic              valid_q,
    output logic              taken_q,
    output logic [DATA_W-1:0] addr_q
);
    // Strobe register: high only for the cycle that follows a request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= 1'b0;
        else
            valid_q <= req;
    end

    // Outcome registers: capture the outcome on a request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
            addr_q  <= '0;
        end else if (req) begin
            taken_q <= taken_in;
            addr_q  <= addr_in;
        end
    end
endmodule

// File: rtl/lcbr_unit.sv
// Module: top of the counted loop branch unit.
// It joins the private counter, the address calculation and the result stage.
// Assumes one branch request at most per cycle; results return one cycle later.
module lcbr_unit #(
    parameter int DATA_W = lcbr_pkg::DATA_W_DEF,
    parameter int OFF_W  = lcbr_pkg::OFF_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mv_en_i,
    input  logic [DATA_W-1:0] mv_val_i,
    input  logic              br_en_i,
    input  logic [DATA_W-1:0] br_pc_i,
    input  logic [OFF_W-1:0]  br_off_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic              res_valid_o,
    output logic              res_taken_o,
    output logic [DATA_W-1:0] res_addr_o
);
    localparam int SHIFT = $clog2(lcbr_pkg::INSN_BYTES);

    logic [DATA_W-1:0] cnt_dec;
    logic              dec_nz;
    logic [DATA_W-1:0] next_addr;

    lcbr_count_reg #(.DATA_W(DATA_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .mv_en       (mv_en_i),
        .mv_val      (mv_val_i),
        .br_en       (br_en_i),
        .cnt         (cnt_o),
        .cnt_dec     (cnt_dec),
        .dec_nonzero (dec_nz)
    );

    lcbr_target_calc #(.DATA_W(DATA_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_tgt (
        .pc        (br_pc_i),
        .off       (br_off_i),
        .taken     (dec_nz),
        .next_addr (next_addr)
    );

    lcbr_result_reg #(.DATA_W(DATA_W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (br_en_i),
        .taken_in (dec_nz),
        .addr_in  (next_addr),
        .valid_q  (res_valid_o),
        .taken_q  (res_taken_o),
        .addr_q   (res_addr_o)
    );

    // The decremented value reaches the outputs only through the counter register.
    logic unused_dec;
    always_comb unused_dec = ^cnt_dec;
endmodule

// File: rtl/lcbr_unit_chk.sv
// Checker: temporal properties of the counted loop branch unit, bound to the top module.
module lcbr_unit_chk #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mv_en_i,
    input logic [DATA_W-1:0] mv_val_i,
    input logic              br_en_i,
    input logic [DATA_W-1:0] br_pc_i,
    input logic [OFF_W-1:0]  br_off_i,
    input logic [DATA_W-1:0] cnt_o,
    input logic              res_valid_o,
    input logic              res_taken_o,
    input logic [DATA_W-1:0] res_addr_o
);
    // R1
    rst_clear_chk: assert property (@(posedge clk) !rst_n |=> (cnt_o == '0) && !res_valid_o);
    // R2
    move_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_en_i && !br_en_i) |=> cnt_o == $past(mv_val_i));
    // R3
    dec_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en_i && !mv_en_i) |=> cnt_o == $past(cnt_o) - DATA_W'(1));
    // R4
    taken_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (res_taken_o == (cnt_o != '0)));
    // R5
    fall_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en_i && ((mv_en_i ? mv_val_i : cnt_o) == DATA_W'(1)))
        |=> !res_taken_o && (res_addr_o == $past(br_pc_i) + DATA_W'(4)));
    // R6
    wrap_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en_i && !mv_en_i && (cnt_o == '0)) |=> res_taken_o && (&cnt_o));
    // R7
    move_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en_i && mv_en_i) |=> cnt_o == $past(mv_val_i) - DATA_W'(1));
    // R8
    valid_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_en_i |=> res_valid_o);
    // R8
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_en_i |=> !res_valid_o);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_en_i && !mv_en_i) |=> $stable(cnt_o));
endmodule

bind lcbr_unit lcbr_unit_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mv_en_i     (mv_en_i),
    .mv_val_i    (mv_val_i),
    .br_en_i     (br_en_i),
    .br_pc_i     (br_pc_i),
    .br_off_i    (br_off_i),
    .cnt_o       (cnt_o),
    .res_valid_o (res_valid_o),
    .res_taken_o (res_taken_o),
    .res_addr_o  (res_addr_o)
);

// File: tb/lcbr_unit_tb_top.sv
// Directed bench for the counted loop branch unit: one task per scenario.
module lcbr_unit_tb_top;
    localparam int DW = 32;
    localparam int OW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mv_en = 1'b0;
    logic [DW-1:0] mv_val = '0;
    logic          br_en = 1'b0;
    logic [DW-1:0] br_pc = '0;
    logic [OW-1:0] br_off = '0;
    logic [DW-1:0] cnt;
    logic          rvalid;
    logic          rtaken;
    logic [DW-1:0] raddr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [DW-1:0] model_cnt = '0;

    always #4 clk = ~clk;

    lcbr_unit #(.DATA_W(DW), .OFF_W(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mv_en_i(mv_en), .mv_val_i(mv_val),
        .br_en_i(br_en), .br_pc_i(br_pc), .br_off_i(br_off),
        .cnt_o(cnt), .res_valid_o(rvalid), .res_taken_o(rtaken), .res_addr_o(raddr)
    );

    task automatic check(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive inputs for one cycle, then return to idle just after the edge.
    task automatic step(input logic m, input logic [DW-1:0] v, input logic b,
                        input logic [DW-1:0] pc, input logic [OW-1:0] off);
        @(negedge clk);
        mv_en = m; mv_val = v; br_en = b; br_pc = pc; br_off = off;
        @(posedge clk);
        #2;
        mv_en = 1'b0; br_en = 1'b0;
    endtask

    function automatic logic [DW-1:0] tgt(input logic [DW-1:0] pc, input logic [OW-1:0] off);
        logic signed [DW-1:0] s;
        s = DW'($signed(off));
        return pc + (s <<< 2);
    endfunction

    // Branch and check the result from a bench model; the move operand is optional.
    task automatic branch(input string req, input logic m, input logic [DW-1:0] v,
                          input logic [DW-1:0] pc, input logic [OW-1:0] off);
        logic [DW-1:0] dec;
        logic          tk;
        dec = (m ? v : model_cnt) - 1;
        tk  = (dec != 0);
        step(m, v, 1'b1, pc, off);
        model_cnt = dec;
        check(req, "valid", DW'(rvalid), 1);
        check(req, "count", cnt, dec);
        check(req, "taken", DW'(rtaken), DW'(tk));
        check(req, "addr", raddr, tk ? tgt(pc, off) : pc + 4);
    endtask

    task automatic t_reset();
        check("R1", "count", cnt, 0);
        check("R1", "valid", DW'(rvalid), 0);
    endtask

    task automatic t_move(input logic [DW-1:0] v);
        step(1'b1, v, 1'b0, '0, '0);
        model_cnt = v;
        check("R2", "count", cnt, v);
        check("R8", "valid after move", DW'(rvalid), 0);
    endtask

    task automatic t_loop();
        t_move(3);
        branch("R3/R4", 1'b0, '0, 32'h0000_1000, 14'h0010);
        branch("R4", 1'b0, '0, 32'h0000_1000, 14'h0010);
        branch("R5", 1'b0, '0, 32'h0000_1000, 14'h0010);
    endtask

    task automatic t_wrap();
        t_move(0);
        branch("R6", 1'b0, '0, 32'h0000_2000, 14'h0004);
        check("R6", "wrapped count", cnt, 32'hFFFF_FFFF);
    endtask

    task automatic t_negative();
        t_move(10);
        branch("R9", 1'b0, '0, 32'h0000_4000, 14'h3FF8);
        check("R9", "target below pc", raddr, 32'h0000_3FE0);
    endtask

    task automatic t_same_cycle();
        t_move(50);
        branch("R7", 1'b1, 32'd1, 32'h0000_5000, 14'h0020);
        check("R7", "fall-through count", cnt, 0);
        branch("R7", 1'b1, 32'd5, 32'h0000_5000, 14'h0020);
        check("R7", "count from move", cnt, 4);
    endtask

    task automatic t_idle();
        step(1'b0, '0, 1'b0, '0, '0);
        check("R8", "valid idle", DW'(rvalid), 0);
        check("R8", "count held", cnt, model_cnt);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        t_reset();
        t_loop();
        t_idle();
        t_wrap();
        t_negative();
        t_same_cycle();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule